// File: doc/BRIEF.md
# Selectable Reference Frequency Divider

This block turns a reference clock (from a crystal oscillator or an external source) into the comparison-frequency strobe that a phase detector consumes. It divides by one of sixteen ratios chosen by a 4-bit code. One bit of the code picks the family of ratios. In one family the ratios are powers of two. In the other the ratios are built on three and five. A three-bit select picks the entry within the family.

The comparison output is a single-cycle pulse at the end of every division period. This suits odd ratios as well as even ones. A second output toggles on every pulse. It gives a half-rate square copy of the comparison frequency that can be driven onto a slow test pin.

A new code is captured by a load strobe but held back until the running period ends. The divider therefore never produces a shortened or stretched comparison period. After reset the divider runs at ratio 2 from a count of zero.

Top module: `refdiv_top`

## Requirements
- R1: With code bit 3 (family bit) at 0, select bits 2:0 = 0..7 give division ratios 2, 4, 8, 16, 32, 64, 128, 256.
- R2: With code bit 3 at 1, select bits 2:0 = 0..7 give division ratios 3, 5, 10, 20, 40, 80, 160, 320.
- R3: For an active ratio N, `cmp_pulse` is high for exactly one clock cycle, and consecutive rising edges are N cycles apart.
- R4: Reset drives `cmp_pulse` and `port_copy` low and selects ratio 2 with the count at zero. The first pulse is high after the second clock edge that follows reset release.
- R5: A code captured by `load` takes effect only when the running period ends. That period keeps the old length, and the next period has the new length.
- R6: When several loads arrive within one period, the last captured code is the one applied at the next period end.
- R7: `port_copy` resets to 0 and inverts on each clock edge at which `cmp_pulse` goes high, and only then.
- R8: Changes on `ratio_code` while `load` is low have no effect on the division ratio.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| ratio_code | input | 4 | Ratio code: bit 3 family, bits 2:0 select |
| load | input | 1 | Captures ratio_code as the pending code |
| cmp_pulse | output | 1 | One-cycle comparison strobe per period |
| port_copy | output | 1 | Half-rate toggle copy of the comparison strobe for a test pin |

## Verification
The bench sweeps all sixteen codes and measures the pulse spacing for each one. This separates the two ratio families and catches any swapped or shifted table entry. Loads issued in the middle of a period check that the old period keeps its length and that the new ratio starts at the following period. This separates deferred switching from immediate switching. Back-to-back loads show which code wins. Code changes made without a load, together with the first-pulse timing after reset, cover the ignore rule and the reset state.

// File: rtl/refdiv_pkg.sv
package refdiv_pkg;
    parameter int SEL_W  = 3;
    parameter int CODE_W = SEL_W + 1;
    parameter int NCODES = 1 << CODE_W;
    parameter int CNT_W  = (1 << SEL_W) + 1;

    typedef logic [CODE_W-1:0] code_t;
    typedef logic [CNT_W-1:0]  ratio_t;

    typedef struct packed {
        logic  valid;
        code_t code;
    } pending_t;

    function automatic ratio_t ratio_of(input code_t c);
        int sel;
        int r;
        sel = int'(c[SEL_W-1:0]);
        if (c[CODE_W-1]) begin
            if (sel == 0) r = 3;
            else          r = 5 << (sel - 1);
        end else begin
            r = 2 << sel;
        end
        return ratio_t'(r);
    endfunction
endpackage

// File: rtl/refdiv_decode.sv
module refdiv_decode
    import refdiv_pkg::*;
(
    input  code_t  code,
    output ratio_t ratio
);
    ratio_t tbl [NCODES];

    for (genvar i = 0; i < NCODES; i++) begin : g_tbl
        assign tbl[i] = ratio_of(code_t'(i));
    end

    assign ratio = tbl[code];
endmodule

// File: rtl/refdiv_shadow.sv
module refdiv_shadow
    import refdiv_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  load,
    input  code_t code_in,
    input  logic  wrap,
    output code_t active_code
);
    pending_t pend_q;
    code_t    act_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= '0;
            act_q  <= '0;
        end else begin
            if (wrap && pend_q.valid) begin
                act_q <= pend_q.code;
            end
            if (load) begin
                pend_q <= '{valid: 1'b1, code: code_in};
            end else if (wrap) begin
                pend_q.valid <= 1'b0;
            end
        end
    end

    assign active_code = act_q;
endmodule

// File: rtl/refdiv_counter.sv
module refdiv_counter
    import refdiv_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  ratio_t ratio,
    output ratio_t cnt,
    output logic   wrap
);
    ratio_t cnt_q;

    assign wrap = (cnt_q == ratio - ratio_t'(1));

    always_ff @(posedge clk) begin
        if (rst)       cnt_q <= '0;
        else if (wrap) cnt_q <= '0;
        else           cnt_q <= cnt_q + ratio_t'(1);
    end

    assign cnt = cnt_q;
endmodule

// File: rtl/refdiv_out.sv
module refdiv_out (
    input  logic clk,
    input  logic rst,
    input  logic wrap,
    output logic pulse,
    output logic half
);
    logic pulse_q, half_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pulse_q <= 1'b0;
            half_q  <= 1'b0;
        end else begin
            pulse_q <= wrap;
            if (wrap) half_q <= ~half_q;
        end
    end

    assign pulse = pulse_q;
    assign half  = half_q;
endmodule

// File: rtl/refdiv_top.sv
module refdiv_top
    import refdiv_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [CODE_W-1:0] ratio_code,
    input  logic             load,
    output logic             cmp_pulse,
    output logic             port_copy
);
    code_t  active_code;
    ratio_t ratio_w;
    ratio_t cnt_q;
    logic   wrap_w;

    refdiv_shadow u_shadow (
        .clk(clk), .rst(rst), .load(load), .code_in(ratio_code),
        .wrap(wrap_w), .active_code(active_code)
    );

    refdiv_decode u_decode (.code(active_code), .ratio(ratio_w));

    refdiv_counter u_counter (
        .clk(clk), .rst(rst), .ratio(ratio_w), .cnt(cnt_q), .wrap(wrap_w)
    );

    refdiv_out u_out (
        .clk(clk), .rst(rst), .wrap(wrap_w), .pulse(cmp_pulse), .half(port_copy)
    );
endmodule

// File: rtl/refdiv_chk.sv
module refdiv_chk
    import refdiv_pkg::*;
(
    input logic   clk,
    input logic   rst,
    input logic   cmp_pulse,
    input logic   port_copy,
    input logic   wrap_w,
    input ratio_t cnt_q,
    input ratio_t ratio_w,
    input code_t  active_code
);
    // R3: strobe lasts one cycle
    assert_pulse_width_R3: assert property (@(posedge clk) disable iff (rst)
        cmp_pulse |=> !cmp_pulse);

    // R3: count stays below the active ratio
    assert_cnt_range_R3: assert property (@(posedge clk) disable iff (rst)
        cnt_q < ratio_w);

    // R4: reset state
    assert_reset_state_R4: assert property (@(posedge clk)
        rst |=> (cnt_q == '0 && ratio_w == ratio_t'(2) && !cmp_pulse && !port_copy));

    // R5: active ratio changes only at a period end
    assert_switch_at_wrap_R5: assert property (@(posedge clk) disable iff (rst)
        !wrap_w |=> $stable(active_code));

    // R7: toggle copy flips exactly with each strobe
    assert_toggle_R7: assert property (@(posedge clk) disable iff (rst)
        (port_copy != $past(port_copy)) == cmp_pulse);

    // R1 R2: decoded ratio always from the legal set (at least 2)
    assert_ratio_min_R1: assert property (@(posedge clk) disable iff (rst)
        ratio_w >= ratio_t'(2));
endmodule

bind refdiv_top refdiv_chk u_chk (
    .clk(clk), .rst(rst), .cmp_pulse(cmp_pulse), .port_copy(port_copy),
    .wrap_w(wrap_w), .cnt_q(cnt_q), .ratio_w(ratio_w), .active_code(active_code)
);

// File: tb/sim_refdiv_top.sv
`timescale 1ns/1ps
module sim_refdiv_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] ratio_code = 4'd0;
    logic       load = 1'b0;
    logic       cmp_pulse, port_copy;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    int exp_lo [8] = '{2, 4, 8, 16, 32, 64, 128, 256};  // R1
    int exp_hi [8] = '{3, 5, 10, 20, 40, 80, 160, 320}; // R2

    always #2.5 clk = ~clk;

    refdiv_top u0 (
        .clk(clk), .rst(rst), .ratio_code(ratio_code), .load(load),
        .cmp_pulse(cmp_pulse), .port_copy(port_copy)
    );

    function automatic int expect_ratio(input logic [3:0] c);
        return c[3] ? exp_hi[c[2:0]] : exp_lo[c[2:0]];
    endfunction

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // counts negedges until cmp_pulse is seen high
    task automatic wait_pulse(output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!cmp_pulse && n < 2000);
    endtask

    task automatic do_load(input logic [3:0] c);
        ratio_code = c;
        load = 1'b1;
        @(negedge clk);
        load = 1'b0;
    endtask

    task automatic t_reset;
        int n;
        rst = 1'b1;
        repeat (3) @(negedge clk);
        check("R4 pulse in reset", cmp_pulse, 0);
        check("R4 port_copy in reset", port_copy, 0);
        rst = 1'b0;
        wait_pulse(n);
        check("R4 first pulse delay", n, 2);
        wait_pulse(n);
        check("R4 default ratio 2", n, 2);
    endtask

    task automatic t_sweep;
        int n;
        for (int c = 0; c < 16; c++) begin
            wait_pulse(n);
            do_load(4'(c));
            wait_pulse(n);
            wait_pulse(n);
            check(c[3] ? "R2 ratio" : "R1 ratio", n, expect_ratio(4'(c)));
            @(negedge clk);
            check("R3 width", cmp_pulse, 0);
        end
    endtask

    task automatic t_deferred;
        int n;
        wait_pulse(n);
        do_load(4'b0100); // 32
        wait_pulse(n);
        wait_pulse(n);
        check("R5 settle 32", n, 32);
        do_load(4'b1001); // 5, loaded one cycle into a 32 period
        wait_pulse(n);
        check("R5 old period kept", n + 1, 32);
        wait_pulse(n);
        check("R5 new period", n, 5);
    endtask

    task automatic t_last_wins;
        int n;
        do_load(4'b1011); // 20
        wait_pulse(n);
        wait_pulse(n);
        check("R6 settle 20", n, 20);
        do_load(4'b0001); // 4
        repeat (3) @(negedge clk);
        do_load(4'b1000); // 3
        wait_pulse(n);
        wait_pulse(n);
        check("R6 last load wins", n, 3);
    endtask

    task automatic t_ignore;
        int n;
        do_load(4'b0010); // 8
        wait_pulse(n);
        wait_pulse(n);
        for (int k = 0; k < 24; k++) begin
            ratio_code = 4'(k * 5 + 1);
            @(negedge clk);
        end
        wait_pulse(n);
        wait_pulse(n);
        check("R8 ratio unchanged", n, 8);
    endtask

    task automatic t_toggle;
        int n;
        logic prev;
        wait_pulse(n);
        prev = port_copy;
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            check("R7 steady between pulses", port_copy, prev);
            wait_pulse(n);
            check("R7 toggles on pulse", port_copy, !prev);
            prev = port_copy;
        end
    endtask

    initial begin
        t_reset();
        t_sweep();
        t_deferred();
        t_last_wins();
        t_ignore();
        t_toggle();
        if (!done) begin
            done = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            total++;
            bad++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule